// File: doc/BRIEF.md
# Beam Line Counter with Blank-Region Interrupt Sources

This block tracks the vertical beam position as an 8-bit line number. It steps once for each scanline pulse, returns to zero at the start of every frame, and wraps from 255 back to 0 by itself. A processor reads the position through a byte register. The two lowest bits of that register always read as zero, so the value it returns changes only once every four lines.

The counter also drives two interrupt-source lines for a parallel interface adapter. The first is a square wave taken from bit 5 of the line number. It toggles every 32 lines and is meant for an edge-sensitive interrupt input. The second is high throughout the lower blank region, lines 240 through 255. Line 240 already has bit 5 set, so the blank-region line cannot be derived from the square wave. It is generated on its own. Both lines are registered and change on the same clock edge as the counter, so each transition is a single clean step.

Top module: `beam_line_counter`

## Requirements
- R1: After reset, the read register, the square-wave output and the blank-region output are all 0.
- R2: A clock cycle with `lineTick` high and `frameStart` low raises the line number by one. A cycle with both inputs low leaves every output unchanged.
- R3: A line tick taken on line 255 returns the line number to 0.
- R4: `frameStart` sets the line number to 0 on the next edge and wins over a `lineTick` in the same cycle.
- R5: `beamRead` equals the current line number with bits 1 and 0 forced to 0.
- R6: `periodicSig` equals bit 5 of the current line number, so it toggles every 32 lines.
- R7: `blankZone` is 1 exactly when the line number is between 240 and 255 inclusive.
- R8: `periodicSig` and `blankZone` change on the same clock edge as the line number that causes the change. There is no extra cycle of delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineTick | input | 1 | One-cycle pulse per scanline |
| frameStart | input | 1 | One-cycle pulse that clears the line number |
| beamRead | output | 8 | Readable line position with bits 1:0 always zero |
| periodicSig | output | 1 | Bit 5 of the line number |
| blankZone | output | 1 | High on lines 240 to 255 |

## Verification
The bench builds the block with its default parameters: 8 line bits, 2 masked low bits, the square wave on bit 5, and the blank region starting at 240. With an 8-bit counter, a full 256-line wrap takes only a few hundred ticks. Many wraps, many 239-to-240 edges and many square-wave edges therefore fit into a short random run. Directed sequences add the cases the random run may miss: a frame pulse and a line tick in the same cycle, idle stretches, and the exact edges at lines 240 and 255-to-0.

// File: rtl/beam_line_pkg.sv
package beam_line_pkg;
  typedef struct packed {
    logic clear;
    logic advance;
  } lineStrobes_t;
endpackage

// File: rtl/beam_line_ctrl.sv
module beam_line_ctrl
  import beam_line_pkg::*;
(
  input  logic         lineTick,
  input  logic         frameStart,
  output lineStrobes_t strobes
);
  // The frame pulse takes priority over a line tick arriving in the same cycle.
  always_comb begin
    strobes.clear   = frameStart;
    strobes.advance = lineTick & ~frameStart;
  end
endmodule

// File: rtl/beam_line_data.sv
module beam_line_data
  import beam_line_pkg::*;
#(
  parameter int LINE_W      = 8,
  parameter int GRAN_LSB    = 2,
  parameter int PERIOD_BIT  = 5,
  parameter int BLANK_START = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  lineStrobes_t      strobes,
  output logic [LINE_W-1:0] lineCount,
  output logic [LINE_W-1:0] readReg,
  output logic              periodicReg,
  output logic              blankReg
);
  localparam logic [LINE_W-1:0] READ_MASK = ~LINE_W'((1 << GRAN_LSB) - 1);
  localparam logic [LINE_W-1:0] BLANK_LIM = LINE_W'(BLANK_START);

  logic [LINE_W-1:0] nextCount;

  always_comb begin
    if (strobes.clear)        nextCount = '0;
    else if (strobes.advance) nextCount = lineCount + LINE_W'(1);
    else                      nextCount = lineCount;
  end

  // All four registers load from nextCount, so they update on the same edge.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineCount   <= '0;
      readReg     <= '0;
      periodicReg <= 1'b0;
      blankReg    <= 1'b0;
    end else begin
      lineCount   <= nextCount;
      readReg     <= nextCount & READ_MASK;
      periodicReg <= nextCount[PERIOD_BIT];
      blankReg    <= (nextCount >= BLANK_LIM);
    end
  end
endmodule

// File: rtl/beam_line_counter.sv
module beam_line_counter
  import beam_line_pkg::*;
#(
  parameter int LINE_W      = 8,
  parameter int GRAN_LSB    = 2,
  parameter int PERIOD_BIT  = 5,
  parameter int BLANK_START = 240
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineTick,
  input  logic              frameStart,
  output logic [LINE_W-1:0] beamRead,
  output logic              periodicSig,
  output logic              blankZone
);
  lineStrobes_t      strobes;
  logic [LINE_W-1:0] lineCount;

  beam_line_ctrl u_ctrl (
    .lineTick   (lineTick),
    .frameStart (frameStart),
    .strobes    (strobes)
  );

  beam_line_data #(
    .LINE_W      (LINE_W),
    .GRAN_LSB    (GRAN_LSB),
    .PERIOD_BIT  (PERIOD_BIT),
    .BLANK_START (BLANK_START)
  ) u_data (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .lineCount   (lineCount),
    .readReg     (beamRead),
    .periodicReg (periodicSig),
    .blankReg    (blankZone)
  );
endmodule

// File: rtl/beam_line_checker.sv
module beam_line_checker #(
  parameter int LINE_W      = 8,
  parameter int GRAN_LSB    = 2,
  parameter int PERIOD_BIT  = 5,
  parameter int BLANK_START = 240
) (
  input logic              clk,
  input logic              rstN,
  input logic              lineTick,
  input logic              frameStart,
  input logic [LINE_W-1:0] lineCount,
  input logic [LINE_W-1:0] beamRead,
  input logic              periodicSig,
  input logic              blankZone
);
  assert_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    (lineTick && !frameStart) |=> lineCount == LINE_W'($past(lineCount) + LINE_W'(1)));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!lineTick && !frameStart) |=> ($stable(lineCount) && $stable(beamRead)));

  assert_frame_clear_R4: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> (lineCount == '0 && beamRead == '0));

  assert_read_coarse_R5: assert property (@(posedge clk) disable iff (!rstN)
    (beamRead[LINE_W-1:GRAN_LSB] == lineCount[LINE_W-1:GRAN_LSB]) &&
    (beamRead[GRAN_LSB-1:0] == '0));

  assert_periodic_bit_R6: assert property (@(posedge clk) disable iff (!rstN)
    periodicSig == lineCount[PERIOD_BIT]);

  assert_blank_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    blankZone == (lineCount >= LINE_W'(BLANK_START)));
endmodule

bind beam_line_counter beam_line_checker #(
  .LINE_W      (LINE_W),
  .GRAN_LSB    (GRAN_LSB),
  .PERIOD_BIT  (PERIOD_BIT),
  .BLANK_START (BLANK_START)
) u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .lineTick    (lineTick),
  .frameStart  (frameStart),
  .lineCount   (lineCount),
  .beamRead    (beamRead),
  .periodicSig (periodicSig),
  .blankZone   (blankZone)
);

// File: tb/beam_line_counter_bench.sv
module beam_line_counter_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       lineTick = 1'b0;
  logic       frameStart = 1'b0;
  logic [7:0] beamRead;
  logic       periodicSig;
  logic       blankZone;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] model = 8'd0;

  always #2.5 clk = ~clk;

  beam_line_counter u_beam_line_counter (
    .clk(clk), .rstN(rstN), .lineTick(lineTick), .frameStart(frameStart),
    .beamRead(beamRead), .periodicSig(periodicSig), .blankZone(blankZone)
  );

  function automatic logic [7:0] expRead(logic [7:0] l); return l & 8'hFC; endfunction
  function automatic logic expPer(logic [7:0] l); return l[5]; endfunction
  function automatic logic expBlank(logic [7:0] l); return l >= 8'd240; endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (model line %0d)", req, act, exp, model);
    end
  endtask

  task automatic checkAll(string req);
    check({req, " R5 read"}, 32'(beamRead), 32'(expRead(model)));
    check({req, " R6 periodic"}, 32'(periodicSig), 32'(expPer(model)));
    check({req, " R7 blank"}, 32'(blankZone), 32'(expBlank(model)));
  endtask

  task automatic step(logic tick, logic frame);
    @(negedge clk);
    lineTick = tick;
    frameStart = frame;
    @(posedge clk);
    if (frame) model = 8'd0;
    else if (tick) model = model + 8'd1;
    #1;
  endtask

  task automatic runTo(logic [7:0] target);
    while (model != target) step(1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 read", 32'(beamRead), 32'd0);
    check("R1 periodic", 32'(periodicSig), 32'd0);
    check("R1 blank", 32'(blankZone), 32'd0);
    @(negedge clk);
    rstN = 1'b1;

    // R2: single ticks, then idle hold
    step(1, 0); checkAll("R2 tick");
    repeat (5) begin step(0, 0); checkAll("R2 idle"); end
    repeat (6) begin step(1, 0); checkAll("R2 tick"); end

    // R8: edges appear on the tick that reaches the line
    runTo(8'd31); checkAll("R8 pre32");
    step(1, 0);
    check("R8 periodic rises at 32", 32'(periodicSig), 32'd1);
    runTo(8'd239);
    check("R8 blank low at 239", 32'(blankZone), 32'd0);
    step(1, 0);
    check("R8 blank high at 240", 32'(blankZone), 32'd1);
    checkAll("R7 at 240");

    // R3: wrap
    runTo(8'd255); checkAll("R3 at 255");
    step(1, 0);
    check("R3 wrap read", 32'(beamRead), 32'd0);
    checkAll("R3 after wrap");

    // R4: frame clear with simultaneous tick
    runTo(8'd100);
    step(1, 1);
    check("R4 clear with tick", 32'(beamRead), 32'd0);
    runTo(8'd250);
    step(0, 1); checkAll("R4 clear idle");

    // Random mix
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      logic t, f;
      t = ($urandom % 4) != 0;
      f = ($urandom % 300) == 0;
      step(t, f);
      checkAll("R2 random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule